// File: doc/BRIEF.md
# Serial Port Controller with Word FIFOs

This block is a memory-mapped controller for a synchronous serial port acting as master. Software sets the word size, enables the port and writes words into an eight-entry transmit queue. A transfer engine takes the oldest queued word and hands it to a word-exchange port. That port returns the word that came back from the far end, and the engine stores it in an eight-entry receive queue. Software then reads the returned words from the same data register it writes to. A loopback setting makes the engine skip the exchange port and copy each transmit word straight into the receive queue. This is useful for self-test.

Software watches the port through a read-only status register and through level-based interrupts. The receive interrupt is raised when at least four words are waiting. The transmit interrupt is raised when four or fewer words are queued. Each interrupt source can be masked, and the unmasked sources are ORed onto one interrupt line. The top of the register window holds eight read-only identification bytes.

Top module: `serial_port_ctl`

## Requirements
- R1: After reset both queues are empty and the interrupt mask is 0. Status (offset 0x0C) reads 0x03, raw interrupts (0x18) read 0x08, masked interrupts (0x1C) read 0, and `irq` is low.
- R2: Bits [3:0] of the format register (0x00) select a word size of that value plus one bits. Every word written to the data register (0x08) is ANDed with a mask of that many ones before it is queued.
- R3: Every word stored in the receive queue is ANDed with the word-size mask that is in force when it is stored.
- R4: Status bits: bit0 is set when the transmit queue is empty, bit1 when it is not full, bit2 when the receive queue is not empty, bit3 when it is full, and bit4 (busy) whenever the transmit queue holds any word.
- R5: Raw interrupt bit2 is set when the receive queue holds 4 or more words, and bit3 when the transmit queue holds 4 or fewer. The mask register (0x14) uses the same bit positions. The masked register (0x1C) reads mask AND raw, and `irq` is high exactly when that value is nonzero.
- R6: Words move only while the enable bit (bit1 of the port control register at 0x04) is set. With the bit clear, no exchange is requested and the transmit queue keeps its contents.
- R7: With loopback (bit0 of 0x04) and enable both set, queued words move into the receive queue in order, without any exchange request.
- R8: Without loopback, the engine holds `xchg_req` high with the oldest transmit word on `xchg_tx` until `xchg_done` is seen. It then removes that word and stores `xchg_rx`. Only one exchange is outstanding at a time, and words go out in write order.
- R9: A write to the data register while the transmit queue holds 8 words is discarded.
- R10: A read of the data register with an empty receive queue returns 0. Otherwise the read returns and removes the oldest word. When the receive queue is full, transfers stall, and each read lets them resume.
- R11: Reads of 0xFE0 to 0xFFC return, one byte per word: 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R12: Unmapped offsets read 0 and ignore writes. The offload register (0x20) accepts writes and reads 0. Writes to status and to the interrupt status registers have no effect.
- R13: The prescale register (0x10) keeps its low 8 bits. The format register keeps 16 bits and the port control register keeps 4 bits, and all three read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read; a data read removes a word |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd` |
| irq | output | 1 | Interrupt, high when any unmasked source is active |
| xchg_req | output | 1 | Exchange request, held until `xchg_done` |
| xchg_tx | output | 16 | Word to send, stable while `xchg_req` is high |
| xchg_done | input | 1 | One-cycle completion of the outstanding exchange |
| xchg_rx | input | 16 | Returned word, valid with `xchg_done` |

## Verification
The assertions assume that `xchg_done` is pulsed for one cycle only while `xchg_req` is high. They also assume that each bus strobe lasts a single cycle and that reads and writes never overlap. The bench models the far end with a responder that waits two cycles after seeing a request and then pulses done once, returning the sent word XOR 0x5AA5. The bench also drives every access as an isolated one-cycle strobe on the falling edge. With the responder and the bus accesses kept within these rules, the hold-until-done and single-outstanding-exchange properties are meaningful. The queue-level properties are then exercised across every fill level from 0 to 8 in both queues.

// File: rtl/sspc_pkg.sv
// Package: shared register offsets, bit positions and identification bytes
// for the serial port controller. Assumes a 12-bit byte-addressed window.
package sspc_pkg;

    localparam int unsigned BUS_AW = 12;
    localparam int unsigned BUS_DW = 32;

    localparam logic [BUS_AW-1:0] OFS_FORMAT  = 12'h000;
    localparam logic [BUS_AW-1:0] OFS_PORTCTL = 12'h004;
    localparam logic [BUS_AW-1:0] OFS_DATA    = 12'h008;
    localparam logic [BUS_AW-1:0] OFS_STATUS  = 12'h00C;
    localparam logic [BUS_AW-1:0] OFS_PRESC   = 12'h010;
    localparam logic [BUS_AW-1:0] OFS_IMASK   = 12'h014;
    localparam logic [BUS_AW-1:0] OFS_IRAW    = 12'h018;
    localparam logic [BUS_AW-1:0] OFS_IMSK    = 12'h01C;
    localparam logic [BUS_AW-1:0] OFS_OFFLOAD = 12'h020;

    // Port control bit positions
    localparam int unsigned PC_LOOP   = 0;
    localparam int unsigned PC_ENABLE = 1;

    // Interrupt bit positions
    localparam int unsigned IRQ_RXLVL = 2;
    localparam int unsigned IRQ_TXLVL = 3;

    // Identification byte for word index 0..7 of the top 32 bytes
    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    id_byte = 8'h22;
            3'd1:    id_byte = 8'h10;
            3'd2:    id_byte = 8'h04;
            3'd3:    id_byte = 8'h00;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/sspc_fifo.sv
// Module: sspc_fifo
// Circular word queue with wrap-around read/write indices and an occupancy
// count from 0 to DEPTH. A push while full and a pop while empty are dropped;
// a push and pop in one cycle leave the count unchanged. The head word is
// presented combinationally. Assumes callers may push and pop together.
module sspc_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned DW    = 16,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] slots [DEPTH];
    logic [PW-1:0] wr_idx, rd_idx;
    logic          do_push, do_pop;

    assign do_push = push && (count != CW'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign head    = slots[rd_idx];

    // Store the incoming word in the slot under the write index
    always_ff @(posedge clk) begin
        if (do_push) slots[wr_idx] <= push_data;
    end

    // Advance indices and track occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_idx <= (wr_idx == PW'(DEPTH - 1)) ? '0 : wr_idx + 1'b1;
            if (do_pop)  rd_idx <= (rd_idx == PW'(DEPTH - 1)) ? '0 : rd_idx + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/sspc_engine.sv
// Module: sspc_engine
// Transfer engine. When enabled, with a word queued and room in the receive
// queue, it either copies the head word to the receive side in one cycle
// (loopback) or opens one exchange and waits for its completion. Assumes
// xchg_done arrives only while an exchange is outstanding, and that only
// this engine pushes the receive queue (so room cannot vanish mid-exchange).
module sspc_engine #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned DW    = 16,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          loopback,
    input  logic [DW-1:0] word_mask,
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] rx_count,
    input  logic [DW-1:0] tx_head,
    output logic          tx_pop,
    output logic          rx_push,
    output logic [DW-1:0] rx_word,
    output logic          xchg_req,
    output logic [DW-1:0] xchg_tx,
    input  logic          xchg_done,
    input  logic [DW-1:0] xchg_rx
);
    logic in_flight;
    logic can_go;

    assign can_go   = enable && (tx_count != '0) && (rx_count != CW'(DEPTH));
    assign xchg_req = in_flight;
    assign xchg_tx  = tx_head;

    // Decide whether a word moves this cycle and which value is stored
    always_comb begin
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        rx_word = '0;
        if (in_flight) begin
            if (xchg_done) begin
                tx_pop  = 1'b1;
                rx_push = 1'b1;
                rx_word = xchg_rx & word_mask;
            end
        end else if (can_go && loopback) begin
            tx_pop  = 1'b1;
            rx_push = 1'b1;
            rx_word = tx_head & word_mask;
        end
    end

    // Open an exchange when idle, close it on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_flight <= 1'b0;
        end else if (in_flight) begin
            if (xchg_done) in_flight <= 1'b0;
        end else if (can_go && !loopback) begin
            in_flight <= 1'b1;
        end
    end

endmodule

// File: rtl/serial_port_ctl.sv
// Module: serial_port_ctl (top)
// Register file, address decode, status and interrupt generation around a
// transmit queue, a receive queue and the transfer engine. Reads return
// data combinationally in the strobe cycle; a data read removes the head of
// the receive queue at the clock edge. Assumes one-cycle strobes that never
// coincide.
module serial_port_ctl #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned SIZE_W = 4,
    parameter int unsigned LEVEL  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [11:0]              bus_addr,
    input  logic                     bus_wr,
    input  logic [31:0]              bus_wdata,
    input  logic                     bus_rd,
    output logic [31:0]              bus_rdata,
    output logic                     irq,
    output logic                     xchg_req,
    output logic [(1<<SIZE_W)-1:0]   xchg_tx,
    input  logic                     xchg_done,
    input  logic [(1<<SIZE_W)-1:0]   xchg_rx
);
    import sspc_pkg::*;

    localparam int unsigned DW = 1 << SIZE_W;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [DW-1:0]     format_q;
    logic [3:0]        portctl_q;
    logic [7:0]        presc_q;
    logic [3:0]        imask_q;

    logic [SIZE_W:0]   nbits;
    logic [DW:0]       wide_mask;
    logic [DW-1:0]     word_mask;

    logic [CW-1:0]     tx_count, rx_count;
    logic [DW-1:0]     tx_head, rx_head;
    logic              tx_push, tx_pop, rx_push, rx_pop;
    logic [DW-1:0]     rx_word;
    logic              enable, loopback;

    logic [4:0]        status;
    logic [3:0]        iraw;
    logic              is_data;

    assign enable   = portctl_q[PC_ENABLE];
    assign loopback = portctl_q[PC_LOOP];
    assign is_data  = (bus_addr == OFS_DATA);

    // Word-size mask: nbits ones, nbits = field + 1
    assign nbits     = {1'b0, format_q[SIZE_W-1:0]} + (SIZE_W+1)'(1);
    assign wide_mask = ((DW+1)'(1) << nbits) - (DW+1)'(1);
    assign word_mask = wide_mask[DW-1:0];

    assign tx_push = bus_wr && is_data && (tx_count != CW'(DEPTH));
    assign rx_pop  = bus_rd && is_data && (rx_count != '0);

    // Status and level interrupts follow the queue counts directly
    assign status = {(tx_count != '0), (rx_count == CW'(DEPTH)),
                     (rx_count != '0), (tx_count != CW'(DEPTH)), (tx_count == '0)};
    always_comb begin
        iraw            = '0;
        iraw[IRQ_RXLVL] = (rx_count >= CW'(LEVEL));
        iraw[IRQ_TXLVL] = (tx_count <= CW'(LEVEL));
    end
    assign irq = |(iraw & imask_q);

    // Transmit queue
    sspc_fifo #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .push_data(bus_wdata[DW-1:0] & word_mask),
        .pop(tx_pop), .head(tx_head), .count(tx_count)
    );

    // Receive queue
    sspc_fifo #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_word),
        .pop(rx_pop), .head(rx_head), .count(rx_count)
    );

    // Transfer engine
    sspc_engine #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .enable(enable), .loopback(loopback), .word_mask(word_mask),
        .tx_count(tx_count), .rx_count(rx_count), .tx_head(tx_head),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
        .xchg_req(xchg_req), .xchg_tx(xchg_tx),
        .xchg_done(xchg_done), .xchg_rx(xchg_rx)
    );

    // Writable configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            format_q  <= '0;
            portctl_q <= '0;
            presc_q   <= '0;
            imask_q   <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_FORMAT:  format_q  <= bus_wdata[DW-1:0];
                OFS_PORTCTL: portctl_q <= bus_wdata[3:0];
                OFS_PRESC:   presc_q   <= bus_wdata[7:0];
                OFS_IMASK:   imask_q   <= bus_wdata[3:0];
                default:     ;
            endcase
        end
    end

    // Read data selection
    always_comb begin
        bus_rdata = '0;
        if (bus_addr[11:5] == 7'h7F) begin
            bus_rdata = {24'b0, id_byte(bus_addr[4:2])};
        end else begin
            case (bus_addr)
                OFS_FORMAT:  bus_rdata = BUS_DW'(format_q);
                OFS_PORTCTL: bus_rdata = BUS_DW'(portctl_q);
                OFS_DATA:    bus_rdata = (rx_count != '0) ? BUS_DW'(rx_head) : '0;
                OFS_STATUS:  bus_rdata = BUS_DW'(status);
                OFS_PRESC:   bus_rdata = BUS_DW'(presc_q);
                OFS_IMASK:   bus_rdata = BUS_DW'(imask_q);
                OFS_IRAW:    bus_rdata = BUS_DW'(iraw);
                OFS_IMSK:    bus_rdata = BUS_DW'(iraw & imask_q);
                default:     bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/sspc_checker.sv
// Module: sspc_checker
// Temporal properties of the controller, bound to the top module. Assumes
// xchg_done pulses only while xchg_req is high.
module sspc_checker #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned DW    = 16,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [11:0]   bus_addr,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [31:0]   bus_rdata,
    input logic          irq,
    input logic [3:0]    imask,
    input logic          enable,
    input logic          loopback,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count,
    input logic          tx_pop,
    input logic          xchg_req,
    input logic [DW-1:0] xchg_tx,
    input logic          xchg_done
);
    // Transmit occupancy never exceeds the depth
    assert_tx_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= CW'(DEPTH));

    // A data write into a full queue with no removal leaves it full
    assert_full_write_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 12'h008 && tx_count == CW'(DEPTH) && !tx_pop)
        |=> (tx_count == CW'(DEPTH)));

    // Request and word hold until completion
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_req && !xchg_done) |=> (xchg_req && $stable(xchg_tx)));

    // A new exchange only opens when the port was enabled
    assert_req_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xchg_req) |-> $past(enable));

    // Idle in loopback never opens an exchange
    assert_loop_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (loopback && !xchg_req) |=> !xchg_req);

    // Interrupt line needs at least one unmasked source
    assert_irq_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (imask != 4'b0));

    // Empty data read returns zero
    assert_empty_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 12'h008 && rx_count == '0) |-> (bus_rdata == 32'b0));

endmodule

bind serial_port_ctl sspc_checker #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_sspc_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq), .imask(imask_q),
    .enable(enable), .loopback(loopback), .tx_count(tx_count),
    .rx_count(rx_count), .tx_pop(tx_pop), .xchg_req(xchg_req),
    .xchg_tx(xchg_tx), .xchg_done(xchg_done)
);

// File: tb/test_serial_port_ctl.sv
// Bench: sweeps word sizes and every queue fill level, models the far end
// with a two-cycle responder, and compares against arithmetic expectations.
module test_serial_port_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        xchg_req;
    logic [15:0] xchg_tx;
    logic        xchg_done = 1'b0;
    logic [15:0] xchg_rx = '0;

    int n_cmp = 0;
    int n_bad = 0;

    logic [15:0] xlog [16];
    int          xn = 0;
    int          wait_cnt = 0;

    always #2 clk = ~clk;

    serial_port_ctl i_serial_port_ctl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .irq(irq), .xchg_req(xchg_req), .xchg_tx(xchg_tx),
        .xchg_done(xchg_done), .xchg_rx(xchg_rx)
    );

    function automatic logic [15:0] far_end(input logic [15:0] w);
        return w ^ 16'h5AA5;
    endfunction

    function automatic logic [31:0] size_mask(input int n);
        return (32'd1 << (n + 1)) - 32'd1;
    endfunction

    // Far-end responder: completes each request two cycles after seeing it
    always @(negedge clk) begin
        if (!rst_n || xchg_done) begin
            xchg_done = 1'b0;
            wait_cnt  = 0;
        end else if (xchg_req) begin
            wait_cnt++;
            if (wait_cnt >= 2) begin
                xchg_rx   = far_end(xchg_tx);
                xchg_done = 1'b1;
                xlog[xn % 16] = xchg_tx;
                xn++;
            end
        end
    end

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  ids [8];
        int          base;
        ids = '{8'h22, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

        // R1: reset state
        do_reset();
        rd(12'h00C, v); chk("R1 status", v, 32'h03);
        rd(12'h018, v); chk("R1 raw", v, 32'h08);
        rd(12'h01C, v); chk("R1 masked", v, 32'h0);
        rd(12'h014, v); chk("R1 mask", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2: word-size mask on write, all sizes, through loopback
        wr(12'h004, 32'h3);
        for (int n = 0; n < 16; n++) begin
            wr(12'h000, n);
            wr(12'h008, 32'hFFFF_FFFF);
            wr(12'h008, 32'h0000_9C35);
            idle(2);
            rd(12'h008, v); chk("R2 all-ones", v, size_mask(n) & 32'hFFFF);
            rd(12'h008, v); chk("R2 pattern", v, size_mask(n) & 32'h9C35);
        end

        // R3: receive masking uses the size in force at store time
        do_reset();
        base = xn;
        wr(12'h000, 15);
        wr(12'h008, 32'hABCD);
        wr(12'h000, 7);
        wr(12'h004, 32'h2);
        idle(12);
        rd(12'h008, v); chk("R3 store mask", v, {16'b0, far_end(16'hABCD)} & 32'hFF);
        chk("R8 sent word", {16'b0, xlog[base % 16]}, 32'hABCD);

        // R8: several exchanges in order
        do_reset();
        base = xn;
        wr(12'h000, 15);
        wr(12'h004, 32'h2);
        for (int i = 0; i < 3; i++) wr(12'h008, 32'h1111 * (i + 1));
        idle(30);
        chk("R8 exchange count", xn - base, 3);
        for (int i = 0; i < 3; i++) begin
            chk("R8 order", {16'b0, xlog[(base + i) % 16]}, 32'h1111 * (i + 1));
            rd(12'h008, v);
            chk("R8 returned", v, {16'b0, far_end(16'(32'h1111 * (i + 1)))});
        end
        chk("R8 req idle", {31'b0, xchg_req}, 32'h0);

        // R6: disabled port keeps words; R7 loopback bit alone does nothing
        do_reset();
        base = xn;
        wr(12'h000, 15);
        wr(12'h008, 32'h0A0A);
        wr(12'h008, 32'h0B0B);
        idle(20);
        chk("R6 no request", xn - base, 0);
        rd(12'h00C, v); chk("R6 status held", v, 32'h12);
        wr(12'h004, 32'h1);
        idle(5);
        rd(12'h00C, v); chk("R6 loop w/o enable", v, 32'h12);
        wr(12'h004, 32'h3);
        idle(5);
        chk("R7 no request", xn - base, 0);
        rd(12'h00C, v); chk("R7 status moved", v, 32'h07);
        rd(12'h008, v); chk("R7 first", v, 32'h0A0A);
        rd(12'h008, v); chk("R7 second", v, 32'h0B0B);

        // R4/R5/R9: every transmit fill level while disabled
        do_reset();
        wr(12'h000, 15);
        for (int k = 0; k <= 8; k++) begin
            rd(12'h00C, v);
            chk("R4 tx level status", v,
                ((k == 0) ? 32'h1 : 0) | ((k != 8) ? 32'h2 : 0) | ((k != 0) ? 32'h10 : 0));
            rd(12'h018, v); chk("R5 tx level raw", v, (k <= 4) ? 32'h8 : 32'h0);
            if (k < 8) wr(12'h008, k + 1);
        end
        wr(12'h008, 32'h77);
        rd(12'h00C, v); chk("R9 still full", v, 32'h10);
        wr(12'h004, 32'h3);
        idle(12);
        for (int k = 0; k < 8; k++) begin
            rd(12'h008, v); chk("R9 order kept", v, k + 1);
        end
        rd(12'h008, v); chk("R10 empty read", v, 32'h0);

        // R4/R5/R10: every receive fill level, with mask on bit2
        do_reset();
        wr(12'h000, 15);
        wr(12'h014, 32'h4);
        wr(12'h004, 32'h3);
        for (int k = 0; k <= 8; k++) begin
            idle(2);
            rd(12'h00C, v);
            chk("R4 rx level status", v,
                32'h3 | ((k != 0) ? 32'h4 : 0) | ((k == 8) ? 32'h8 : 0));
            rd(12'h018, v); chk("R5 rx level raw", v, 32'h8 | ((k >= 4) ? 32'h4 : 0));
            rd(12'h01C, v); chk("R5 masked", v, (k >= 4) ? 32'h4 : 32'h0);
            chk("R5 irq", {31'b0, irq}, (k >= 4) ? 32'h1 : 32'h0);
            if (k < 8) wr(12'h008, 32'h40 + k);
        end
        wr(12'h008, 32'h55);
        wr(12'h008, 32'h66);
        idle(4);
        rd(12'h00C, v); chk("R10 stalled", v, 32'h1E);
        rd(12'h018, v); chk("R5 both levels", v, 32'hC);
        for (int k = 0; k < 8; k++) begin
            rd(12'h008, v); chk("R10 drain", v, 32'h40 + k);
        end
        rd(12'h008, v); chk("R10 resumed first", v, 32'h55);
        rd(12'h008, v); chk("R10 resumed second", v, 32'h66);
        rd(12'h008, v); chk("R10 empty again", v, 32'h0);
        wr(12'h014, 32'h8);
        idle(1);
        chk("R5 tx irq", {31'b0, irq}, 32'h1);

        // R11: identification bytes
        for (int i = 0; i < 8; i++) begin
            rd(12'hFE0 + 12'(4 * i), v); chk("R11 id", v, {24'b0, ids[i]});
        end

        // R12: unmapped, offload and read-only registers
        do_reset();
        wr(12'h000, 32'h5);
        wr(12'h024, 32'hFFFF);
        wr(12'h800, 32'hFFFF);
        rd(12'h000, v); chk("R12 unmapped write", v, 32'h5);
        rd(12'h024, v); chk("R12 unmapped read", v, 32'h0);
        rd(12'h800, v); chk("R12 unmapped read far", v, 32'h0);
        wr(12'h020, 32'h3);
        rd(12'h020, v); chk("R12 offload", v, 32'h0);
        wr(12'h00C, 32'hFF);
        rd(12'h00C, v); chk("R12 status ro", v, 32'h03);
        wr(12'h018, 32'h0);
        rd(12'h018, v); chk("R12 raw ro", v, 32'h08);
        wr(12'h01C, 32'hF);
        rd(12'h01C, v); chk("R12 masked ro", v, 32'h0);

        // R13: readback widths
        wr(12'h010, 32'h1FF);
        rd(12'h010, v); chk("R13 prescale", v, 32'hFF);
        wr(12'h000, 32'h1_ABC7);
        rd(12'h000, v); chk("R13 format", v, 32'hABC7);
        wr(12'h004, 32'hFD);
        rd(12'h004, v); chk("R13 port control", v, 32'hD);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule